// File: doc/BRIEF.md
# Serial-Bus Configuration Register Slave

This block is a two-wire serial slave (SMBus/I2C compatible) that holds a small bank of 8-bit configuration registers. It answers at the 7-bit address 1101001 (D2h for a write, D3h for a read). SCL and SDA are sampled by the system clock through two-flop synchronizers. SDA is driven open-drain: the block only ever pulls the line low through `sda_oe`. Every register value is also presented in parallel on `cfg_o` so that the surrounding logic can use it as control.

The first byte after the address is a command. When its top bit is set, the transfer is a single-byte access, and the low seven bits name the register. When its top bit is clear, the transfer is a block access that always starts at register 0 and walks upward. A block write carries a byte count ahead of its data. A block read answers with a count first. The master may end a block after any whole byte. Two bits of register 0 mirror a hardware strap input and cannot be written.

Top module: `smb_cfg_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits are 1101001. On any other address it gives no acknowledge and keeps SDA released, including the acknowledge slots, until the next start condition.
- R2: After reset the registers read register0 = 4Ch with bits 1:0 replaced by `strap_i`, register1 = 7Fh, register2 = 00h and register3 = FFh. `cfg_o[8*i+7:8*i]` shows register i.
- R3: A byte write sends address D2h, then a command with bit 7 = 1 and the offset in bits 6:0, then one data byte. The block acknowledges all three bytes and stores the data in that register.
- R4: A byte read sends D2h and the command (bit 7 = 1, offset in bits 6:0), then a repeated start and D3h. The block then returns the addressed register, MSB first. An offset at or above the register count reads 00h.
- R5: A block write sends D2h, command 00h, a count byte, and then data bytes. The data bytes go to register 0, 1, 2 and so on. The block acknowledges every byte, including bytes past the last register, which are dropped. A stop after any complete byte ends the write, and the bytes already received are kept.
- R6: A block read sends D2h and command 00h, then a repeated start and D3h. The block returns the register count (4) and then registers from 0 upward for as long as the master acknowledges. A master NACK ends the read.
- R7: Register 0 bits 1:0 always read the current `strap_i` value, and writes to those bits are dropped. The other bits of register 0 are writable.
- R8: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start at any point begins a new address phase. A stop at any point, including mid-byte, returns the block to idle with SDA released.
- R9: The block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Hardware strap levels shown in register 0 bits 1:0 |
| cfg_o | output | 32 | All register values, register i in bits 8i+7:8i |

## Verification
The hardest conditions to reach from the ports are the cases where the bus misbehaves. These include a foreign address followed by further bytes, a start that cuts into a command byte, a stop partway through a byte, and block writes that run past the last register or stop before their count is reached. The bench builds each of these directly with its own bit-level master tasks. It checks the acknowledge slots and later reads, which shows that no state leaked across. Random byte and block traffic with random offsets, lengths and data then runs against a register model kept in the bench.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  localparam logic [6:0] DEV_ADDR = 7'h69;
  localparam int         STRAP_W  = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_SACK, ST_TX, ST_MACK, ST_WAIT} bus_st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_t;

  // Power-up value of register i
  function automatic logic [7:0] cfg_default(input int i);
    case (i)
      0:       return 8'h4C;
      1:       return 8'h7F;
      2:       return 8'h00;
      3:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of register i that come from hardware and ignore writes
  function automatic logic [7:0] ro_mask(input int i);
    return (i == 0) ? 8'h03 : 8'h00;
  endfunction

  function automatic logic [7:0] view_of(input logic [7:0] q,
                                         input logic [STRAP_W-1:0] strap,
                                         input int i);
    logic [7:0] hw;
    hw = {{(8-STRAP_W){1'b0}}, strap};
    return (q & ~ro_mask(i)) | (hw & ro_mask(i));
  endfunction

  // Byte placed on the wire for the next read slot
  function automatic logic [7:0] tx_byte(input logic send_cnt,
                                         input logic [7:0] rd,
                                         input int nregs);
    return send_cnt ? 8'(nregs) : rd;
  endfunction

endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_evt = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_evt  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/smbcfg_fsm.sv
module smbcfg_fsm
  import smbcfg_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic [6:0] rd_addr,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  bus_st_t    st;
  rx_kind_t   kind;
  logic [2:0] bitcnt;
  logic [7:0] sh, txsh;
  logic       got, rw, send_cnt, mnack;
  logic [6:0] ptr;
  logic [7:0] nxt_tx;

  assign rd_addr = ptr;
  assign nxt_tx  = tx_byte(send_cnt, rd_data, NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_ADDR; bitcnt <= '0; sh <= '0; txsh <= '0;
      got <= 1'b0; rw <= 1'b0; send_cnt <= 1'b0; mnack <= 1'b1; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0; got <= 1'b0;
      end else if (start_evt) begin
        st <= ST_RX; kind <= K_ADDR; bitcnt <= '0; got <= 1'b0; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (st == ST_RX) begin
          sh     <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) got <= 1'b1;
        end else if (st == ST_MACK) begin
          mnack <= sda_s;
        end
      end else if (scl_fall) begin
        case (st)
          ST_RX: if (got) begin
            got <= 1'b0; bitcnt <= '0; st <= ST_SACK; sda_oe <= 1'b1;
            case (kind)
              K_ADDR: if (sh[7:1] == DEV_ADDR) begin
                rw <= sh[0]; kind <= K_CMD;
              end else begin
                st <= ST_WAIT; sda_oe <= 1'b0;
              end
              K_CMD: begin
                ptr      <= sh[7] ? sh[6:0] : 7'd0;
                send_cnt <= ~sh[7];
                kind     <= sh[7] ? K_DATA : K_CNT;
              end
              K_CNT:  kind <= K_DATA;
              default: begin
                wr_en   <= (32'(ptr) < NREGS);
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 7'd1;
              end
            endcase
          end
          ST_SACK: begin
            if (rw) begin
              txsh <= nxt_tx; sda_oe <= ~nxt_tx[7]; bitcnt <= '0; st <= ST_TX;
              if (send_cnt) send_cnt <= 1'b0; else ptr <= ptr + 7'd1;
            end else begin
              st <= ST_RX; sda_oe <= 1'b0;
            end
          end
          ST_TX: begin
            if (bitcnt == 3'd7) begin
              st <= ST_MACK; sda_oe <= 1'b0; bitcnt <= '0;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_MACK: begin
            if (mnack) begin
              st <= ST_WAIT;
            end else begin
              txsh <= nxt_tx; sda_oe <= ~nxt_tx[7]; bitcnt <= '0; st <= ST_TX;
              if (send_cnt) send_cnt <= 1'b0; else ptr <= ptr + 7'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: after a foreign address the line stays released
  p_wait_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe);

  // R8: a start opens a new address phase
  p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !stop_evt) |=> (st == ST_RX && kind == K_ADDR && bitcnt == 3'd0));

  // R8: a stop idles the block with SDA free
  p_stop_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe));

  // R9: data line moves only while the clock is low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

endmodule

// File: rtl/smbcfg_bank.sv
module smbcfg_bank
  import smbcfg_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [6:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [6:0]         rd_addr,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [7:0]         rd_data,
  output logic [NREGS*8-1:0] cfg_o
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [7:0] q    [NREGS];
  logic [7:0] view [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q[i] <= cfg_default(i);
      else if (wr_en && wr_addr[IW-1:0] == IW'(i))  q[i] <= wr_data;
    end
    assign view[i]        = view_of(q[i], strap_i, i);
    assign cfg_o[i*8 +: 8] = view[i];
  end

  assign rd_data = (32'(rd_addr) < NREGS) ? view[rd_addr[IW-1:0]] : 8'h00;

  // R5: the control side never writes past the bank
  p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < NREGS));

  // R3: a write to register 0 lands on the next cycle
  p_wr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'd0) |=> (q[0] == $past(wr_data)));

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smbcfg_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREGS*8-1:0] cfg_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  smbcfg_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smbcfg_fsm #(.NREGS(NREGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smbcfg_bank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .strap_i(strap_i),
    .rd_data(rd_data), .cfg_o(cfg_o)
  );

endmodule

// File: tb/smb_cfg_regs_tb.sv
module smb_cfg_regs_tb;
  localparam int CLK_NS = 10;
  localparam int Q      = 6;
  localparam int NR     = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        sda_oe;
  logic [31:0] cfg;
  wire         sda_line = m_sda & ~sda_oe;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] mdl [NR];
  logic [7:0] buf8 [8];

  smb_cfg_regs u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                      .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg));

  always #(CLK_NS/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run hung act=%0d exp=done", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [7:0] exp_rd(input int off);
    if (off >= NR) return 8'h00;
    if (off == 0)  return (mdl[0] & 8'hFC) | {6'b0, strap};
    return mdl[off];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1; tick(Q); scl = 1; tick(Q); m_sda = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bstop();
    m_sda = 0; tick(Q); scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask
  task automatic wbit(input logic b);
    m_sda = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask
  task automatic rbit(output logic b);
    m_sda = 1; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nack);
  endtask
  task automatic rbyte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(nack);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, input string req);
    logic a0, a1, a2;
    bstart(); wbyte(8'hD2, a0); wbyte(8'h80 | 8'(off), a1); wbyte(d, a2); bstop();
    check({req, " byte write acks"}, {a0, a1, a2}, 0);
    if (off < NR) mdl[off] = d;
  endtask

  task automatic byte_read(input int off, input string req);
    logic a0, a1, a2; logic [7:0] d;
    bstart(); wbyte(8'hD2, a0); wbyte(8'h80 | 8'(off), a1);
    bstart(); wbyte(8'hD3, a2); rbyte(d, 1'b1); bstop();
    check({req, " byte read acks"}, {a0, a1, a2}, 0);
    check({req, " byte read data"}, d, exp_rd(off));
  endtask

  task automatic block_write(input int n, input string req);
    logic a; int nak = 0;
    bstart(); wbyte(8'hD2, a); nak += a; wbyte(8'h00, a); nak += a;
    wbyte(8'(n), a); nak += a;
    for (int i = 0; i < n; i++) begin
      wbyte(buf8[i], a); nak += a;
      if (i < NR) mdl[i] = buf8[i];
    end
    bstop();
    check({req, " block write acks"}, nak, 0);
  endtask

  task automatic block_read(input int n, input string req);
    logic a0, a1, a2; logic [7:0] d;
    bstart(); wbyte(8'hD2, a0); wbyte(8'h00, a1);
    bstart(); wbyte(8'hD3, a2);
    check({req, " block read acks"}, {a0, a1, a2}, 0);
    rbyte(d, 1'b0);
    check({req, " block read count"}, d, NR);
    for (int i = 0; i < n; i++) begin
      rbyte(d, (i == n - 1));
      check({req, " block read data"}, d, exp_rd(i));
    end
    bstop();
  endtask

  task automatic check_cfg(input string req);
    check({req, " cfg_o"}, cfg, {exp_rd(3), exp_rd(2), exp_rd(1), exp_rd(0)});
  endtask

  initial begin
    logic a, b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h4C; mdl[1] = 8'h7F; mdl[3] = 8'hFF;
    tick(5); rst_n = 1; tick(5);

    // R2 reset values
    check("R2 reset cfg", cfg, 32'hFF007F4E);
    check("R2 sda released", sda_oe, 0);
    for (int i = 0; i < NR; i++) byte_read(i, "R2/R4");

    // R1 foreign address: no ack, stays released for later bytes
    bstart(); wbyte(8'hA4, a); wbyte(8'h00, b); bstop();
    check("R1 foreign addr nack", a, 1);
    check("R1 released after mismatch", b, 1);
    check_cfg("R1");

    // R3 / R7 read-only strap bits
    byte_write(0, 8'hFF, "R3");
    byte_read(0, "R7");
    strap = 2'b01; tick(4);
    check_cfg("R7 strap follows");
    byte_read(0, "R7");
    byte_write(2, 8'h5A, "R3");
    check_cfg("R3");
    byte_read(9, "R4 out of range");

    // R5 long block write drops extras; early stop keeps bytes
    for (int i = 0; i < 6; i++) buf8[i] = 8'h11 * 8'(i + 1);
    block_write(6, "R5 past end");
    check_cfg("R5");
    buf8[0] = 8'hC3; buf8[1] = 8'h3C;
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd4, a);
    wbyte(buf8[0], a); wbyte(buf8[1], b); bstop();
    mdl[0] = 8'hC3; mdl[1] = 8'h3C;
    check("R5 early stop ack", b, 0);
    check_cfg("R5 early stop");

    // R6 block read, full and short
    block_read(NR, "R6");
    block_read(2, "R6 short");

    // R8 start inside a command byte, then a clean write
    bstart(); wbyte(8'hD2, a); wbit(1); wbit(0); wbit(0);
    byte_write(3, 8'h96, "R8 restart");
    // R8 stop in the middle of a byte
    bstart(); wbyte(8'hD2, a); wbit(1); wbit(0); bstop();
    check_cfg("R8 mid-byte stop");
    byte_read(3, "R8");

    // constrained random traffic
    for (int t = 0; t < 40; t++) begin
      int op = $urandom % 4;
      int off = $urandom % 6;
      case (op)
        0: byte_write(off, 8'($urandom), "R3 rnd");
        1: byte_read(off, "R4 rnd");
        2: begin
          int n = 1 + ($urandom % 5);
          for (int i = 0; i < n; i++) buf8[i] = 8'($urandom);
          block_write(n, "R5 rnd");
        end
        default: block_read(1 + ($urandom % NR), "R6 rnd");
      endcase
      if (t % 8 == 7) begin strap = 2'($urandom); tick(4); end
      check_cfg("R2 rnd");
    end

    summary();
    $finish;
  end
endmodule